// File: doc/BRIEF.md
# Sectored Flash Command Controller

This block is the host-facing control logic of a small sectored parallel flash array. The host reads and writes over a simple synchronous bus. Reads that are not part of a command return array contents. Writes are never stored directly. Instead, short write sequences that begin with a two-write unlock are decoded into commands: return to read mode, identifier read, sector protection read, program, and sector erase.

Program and erase run as embedded operations with a fixed latency, counted in clock cycles. While one of them runs, `busy` is high and every read returns a status word. Bit 7 of that word is the data-polling flag. A per-sector protect mask, set by parameter, blocks program and erase. A program aimed at a protected sector is dropped. An erase aimed at a protected sector stalls for a timeout period and then gives up without erasing.

The bus works in byte mode or in word mode, chosen by `bus16`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While reset is held and after it is released, `busy` is low, the controller is in read mode, and every byte of the array reads FFh. Read data appears on `rdata` in the cycle after the one in which `re` is sampled high.
- R2: With `bus16` low, a read at any address returns that byte in `rdata[7:0]`, with `rdata[15:8]` zero. With `bus16` high, address bit 0 is ignored: the byte at the even address appears on `rdata[7:0]` and the byte at the odd address on `rdata[15:8]`.
- R3: Commands start with two unlock writes, AAh to address 555h and then 55h to address AAAh. Only `wdata[7:0]` and all 12 address bits are compared. Any write that does not match the expected step returns the controller to read mode without changing the array, and so does a third write of F0h. Reads in the middle of a sequence return array data and do not break the sequence.
- R4: A third write of 90h makes the next read a single identifier access, after which the controller is back in read mode. If address bit 1 of that read is 0, it returns 00E8h. If address bit 1 is 1, it returns 0001h when the addressed sector is protected and 0000h when it is not.
- R5: A third write of A0h, followed by a data write, programs that byte (or word when `bus16` is high) at the write address. `busy` is then high for exactly PROG_LAT cycles, after which the array holds the new data.
- R6: While a program runs, every read returns bit 7 equal to the complement of bit 7 of the low byte being programmed. Only bit 7 of a status word is meaningful.
- R7: Erase is the sequence AAh@555h, 55h@AAAh, 80h, AAh@555h, 55h@AAAh, then 30h to any address inside the target sector. `busy` is high for ERASE_LAT cycles and reads return bit 7 = 0. Afterwards every byte of that sector reads FFh and the other sectors are unchanged.
- R8: A program whose target lies in a protected sector leaves `busy` low and the array unchanged.
- R9: An erase of a protected sector holds `busy` high for PROT_TO cycles with status bit 7 = 0, then returns to read mode with no byte changed.
- R10: Writes made while `busy` is high are ignored: they neither start nor shorten an operation, and the controller is in plain read mode afterwards.
- R11: Sector index is address bits [ARR_W-1 -: SECT_W] (bits 7:6 by default), and sector 2 is the only protected sector by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus16 | input | 1 | 1 = word bus, 0 = byte bus |
| we | input | 1 | Write strobe for one cycle |
| re | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W | Byte address |
| wdata | input | 16 | Write data; only the low byte is used for commands |
| rdata | output | 16 | Read data, registered |
| busy | output | 1 | High while a program, erase or protected-erase timeout runs |

## Verification
Two functions can coincide. The last cycle of an embedded operation can fall on the same cycle as a status read. The controller can also be collecting a command sequence when an ordinary array read arrives. The bench waits exactly PROG_LAT-1 cycles after the data write and then reads. That read must still return the inverted polling bit, and the next read must return the programmed value. In a second case, the bench reads between unlock writes and expects array data, and it also expects the sequence to go on and program the array.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W    = 12,
  parameter int ARR_W     = 8,
  parameter int SECT_W    = 2,
  parameter int PROG_LAT  = 16,
  parameter int ERASE_LAT = 256,
  parameter int PROT_TO   = 64,
  parameter logic [(1<<SECT_W)-1:0] PROT_MASK = 'b0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus16,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              busy
);
  localparam int DEPTH  = 1 << ARR_W;
  localparam int MAXLAT = (ERASE_LAT > PROG_LAT) ? ((ERASE_LAT > PROT_TO) ? ERASE_LAT : PROT_TO)
                                                 : ((PROG_LAT > PROT_TO) ? PROG_LAT : PROT_TO);
  localparam int CW     = $clog2(MAXLAT + 1);

  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_AUTO, S_PDATA, S_E1, S_E2, S_E3, S_PROG, S_ERASE, S_TOUT
  } st_t;

  st_t               state;
  logic [CW-1:0]     cnt;
  logic [ARR_W-1:0]  taddr;
  logic [15:0]       tdata;
  logic              t16;
  logic [SECT_W-1:0] tsec;
  logic [7:0]        mem [DEPTH];
  logic [15:0]       rd_n;

  wire [ARR_W-1:0]  ia   = addr[ARR_W-1:0];
  wire [ARR_W-1:0]  ea   = {ia[ARR_W-1:1], 1'b0};
  wire [ARR_W-1:0]  oa   = {ia[ARR_W-1:1], 1'b1};
  wire [SECT_W-1:0] isec = ia[ARR_W-1 -: SECT_W];
  wire [7:0]        wd   = wdata[7:0];
  wire unl1 = (addr == ADDR_W'(12'h555)) && (wd == 8'hAA);
  wire unl2 = (addr == ADDR_W'(12'hAAA)) && (wd == 8'h55);
  wire erase_phase = (state == S_ERASE) || (state == S_TOUT);
  wire done        = busy && (cnt == '0);

  assign busy = (state == S_PROG) || erase_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_READ;
      cnt   <= '0;
      taddr <= '0;
      tdata <= '0;
      t16   <= 1'b0;
      tsec  <= '0;
    end else begin
      case (state)
        S_READ:  if (we) state <= unl1 ? S_U1 : S_READ;
        S_U1:    if (we) state <= unl2 ? S_U2 : S_READ;
        S_U2:    if (we) begin
                   case (wd)
                     8'h90:   state <= S_AUTO;
                     8'hA0:   state <= S_PDATA;
                     8'h80:   state <= S_E1;
                     default: state <= S_READ;
                   endcase
                 end
        S_AUTO:  if (re || we) state <= S_READ;
        S_PDATA: if (we) begin
                   if (PROT_MASK[isec]) state <= S_READ;
                   else begin
                     state <= S_PROG;
                     cnt   <= CW'(PROG_LAT - 1);
                     taddr <= bus16 ? ea : ia;
                     tdata <= wdata;
                     t16   <= bus16;
                   end
                 end
        S_E1:    if (we) state <= unl1 ? S_E2 : S_READ;
        S_E2:    if (we) state <= unl2 ? S_E3 : S_READ;
        S_E3:    if (we) begin
                   if (wd != 8'h30) state <= S_READ;
                   else begin
                     tsec <= isec;
                     if (PROT_MASK[isec]) begin
                       state <= S_TOUT;
                       cnt   <= CW'(PROT_TO - 1);
                     end else begin
                       state <= S_ERASE;
                       cnt   <= CW'(ERASE_LAT - 1);
                     end
                   end
                 end
        default: if (done) state <= S_READ;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (done && state == S_PROG) begin
      mem[taddr] <= tdata[7:0];
      if (t16) mem[{taddr[ARR_W-1:1], 1'b1}] <= tdata[15:8];
    end else if (done && state == S_ERASE) begin
      for (int i = 0; i < DEPTH; i++)
        if ((i >> (ARR_W - SECT_W)) == int'(tsec)) mem[i] <= 8'hFF;
    end
  end

  always_comb begin
    if (busy)
      rd_n = {8'h00, (state == S_PROG) ? ~tdata[7] : 1'b0, 7'h00};
    else if (state == S_AUTO)
      rd_n = ia[1] ? {15'h0000, PROT_MASK[isec]} : 16'h00E8;
    else if (bus16)
      rd_n = {mem[oa], mem[ea]};
    else
      rd_n = {8'h00, mem[ia]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= rd_n;
  end
endmodule

module flash_cmd_ctrl_chk #(
  parameter int PROG_LAT  = 16,
  parameter int ERASE_LAT = 256,
  parameter int PROT_TO   = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        we,
  input logic        re,
  input logic        busy,
  input logic        erase_phase,
  input logic [15:0] rdata
);
  localparam int MAXLAT = (ERASE_LAT > PROG_LAT) ? ((ERASE_LAT > PROT_TO) ? ERASE_LAT : PROT_TO)
                                                 : ((PROG_LAT > PROT_TO) ? PROG_LAT : PROT_TO);
  localparam int RW = $clog2(MAXLAT + 1);

  logic [RW-1:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) run <= '0;
    else                 run <= run + 1'b1;
  end

  p_calm_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy);

  p_busy_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < RW'(MAXLAT)));

  p_busy_from_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(we));

  p_erase_poll_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(re && erase_phase) |-> (rdata[7] == 1'b0));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(
  .PROG_LAT(PROG_LAT), .ERASE_LAT(ERASE_LAT), .PROT_TO(PROT_TO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .re(re), .busy(busy),
  .erase_phase(erase_phase), .rdata(rdata)
);

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
  localparam int PLAT = 16;
  localparam int ELAT = 256;
  localparam int TOUT = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus16 = 1'b0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        busy;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [256];

  flash_cmd_ctrl #(
    .ADDR_W(12), .ARR_W(8), .SECT_W(2), .PROG_LAT(PLAT), .ERASE_LAT(ELAT),
    .PROT_TO(TOUT), .PROT_MASK(4'b0100)
  ) u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus16(bus16), .we(we), .re(re),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp,
                     input logic [15:0] mask);
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (mask %h)", tag, act, exp, mask);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] q);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0;
    q = rdata;
  endtask

  task automatic unlock();
    wr(12'h555, 16'h00AA);
    wr(12'hAAA, 16'h0055);
  endtask

  task automatic prog(input logic [11:0] a, input logic [15:0] d);
    unlock();
    wr(12'h555, 16'h00A0);
    wr(a, d);
  endtask

  task automatic erase_seq(input logic [11:0] a);
    unlock();
    wr(12'h555, 16'h0080);
    unlock();
    wr(a, 16'h0030);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic sweep_bytes(input string tag);
    logic [15:0] q;
    for (int a = 0; a < 256; a++) begin
      rd(12'(a), q);
      chk(tag, q, {8'h00, model[a]}, 16'hFFFF);
    end
  endtask

  initial begin
    logic [15:0] q;
    int n;
    logic [7:0] d8;
    for (int a = 0; a < 256; a++) model[a] = 8'hFF;

    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {15'h0, busy}, 16'h0, 16'hFFFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", {15'h0, busy}, 16'h0, 16'hFFFF);
    sweep_bytes("R1 blank array");

    for (int a = 0; a < 128; a++) begin
      d8 = 8'(a * 37 + 11);
      prog(12'(a), {8'h00, d8});
      wait_idle(n);
      chk("R5 program latency", 16'(n), 16'(PLAT), 16'hFFFF);
      model[a] = d8;
    end
    sweep_bytes("R5 R8 R11 after programs");

    for (int a = 8'hC0; a < 8'hC8; a++) begin
      d8 = 8'(a * 53 + 7);
      prog(12'(a), {8'h00, d8});
      rd(12'(a), q);
      chk("R6 polling bit", q, {8'h00, ~d8[7], 7'h00}, 16'h0080);
      wait_idle(n);
      rd(12'(a), q);
      chk("R6 true value after program", q, {8'h00, d8}, 16'hFFFF);
      model[a] = d8;
    end

    prog(12'h0D0, 16'h0012);
    repeat (PLAT - 1) @(negedge clk);
    rd(12'h0D0, q);
    chk("R6 poll on final busy cycle", q, 16'h0080, 16'h0080);
    chk("R5 busy low after completion", {15'h0, busy}, 16'h0, 16'hFFFF);
    rd(12'h0D0, q);
    chk("R5 data after final-cycle poll", q, 16'h0012, 16'hFFFF);
    model[8'hD0] = 8'h12;

    bus16 = 1'b1;
    for (int a = 0; a < 256; a += 2) begin
      rd(12'(a), q);
      chk("R2 word even", q, {model[a + 1], model[a]}, 16'hFFFF);
      rd(12'(a + 1), q);
      chk("R2 word odd addr", q, {model[a + 1], model[a]}, 16'hFFFF);
    end
    prog(12'h0E1, 16'h5AC3);
    rd(12'h0E0, q);
    chk("R6 word poll", q, 16'h0000, 16'h0080);
    wait_idle(n);
    chk("R5 word latency", 16'(n), 16'(PLAT - 1), 16'hFFFF);
    model[8'hE0] = 8'hC3;
    model[8'hE1] = 8'h5A;
    rd(12'h0E0, q);
    chk("R2 R5 word readback", q, 16'h5AC3, 16'hFFFF);
    unlock();
    wr(12'h555, 16'h0090);
    rd(12'h0002, q);
    chk("R4 word protect sector 0", q, 16'h0000, 16'h00FF);
    unlock();
    wr(12'h555, 16'h0090);
    rd(12'h0000, q);
    chk("R4 word identifier", q, 16'h00E8, 16'h00FF);
    bus16 = 1'b0;
    rd(12'h0E0, q);
    chk("R2 byte low", q, 16'h00C3, 16'hFFFF);
    rd(12'h0E1, q);
    chk("R2 byte high", q, 16'h005A, 16'hFFFF);

    wr(12'h555, 16'h00AA);
    wr(12'hAAA, 16'h0054);
    wr(12'h555, 16'h00A0);
    wr(12'h010, 16'h0000);
    chk("R3 bad unlock no busy", {15'h0, busy}, 16'h0, 16'hFFFF);
    rd(12'h010, q);
    chk("R3 bad unlock array kept", q, {8'h00, model[8'h10]}, 16'hFFFF);
    unlock();
    wr(12'h555, 16'h00F0);
    wr(12'h011, 16'h0000);
    chk("R3 reset command no busy", {15'h0, busy}, 16'h0, 16'hFFFF);
    rd(12'h011, q);
    chk("R3 reset command array kept", q, {8'h00, model[8'h11]}, 16'hFFFF);
    wr(12'h555, 16'h00AA);
    rd(12'h020, q);
    chk("R3 read mid-sequence", q, {8'h00, model[8'h20]}, 16'hFFFF);
    wr(12'hAAA, 16'h0055);
    wr(12'h555, 16'h00A0);
    wr(12'h0F0, 16'h003C);
    wait_idle(n);
    chk("R3 sequence survives read", 16'(n), 16'(PLAT), 16'hFFFF);
    model[8'hF0] = 8'h3C;
    rd(12'h0F0, q);
    chk("R3 program after mid read", q, 16'h003C, 16'hFFFF);

    for (int s = 0; s < 4; s++) begin
      unlock();
      wr(12'h555, 16'h0090);
      rd(12'(s * 64 + 2), q);
      chk("R4 R11 protect status", q, (s == 2) ? 16'h0001 : 16'h0000, 16'hFFFF);
      unlock();
      wr(12'h555, 16'h0090);
      rd(12'(s * 64), q);
      chk("R4 identifier", q, 16'h00E8, 16'hFFFF);
      rd(12'(s * 64), q);
      chk("R4 back to read mode", q, {8'h00, model[s * 64]}, 16'hFFFF);
    end

    prog(12'h085, 16'h0000);
    chk("R8 protected program no busy", {15'h0, busy}, 16'h0, 16'hFFFF);
    rd(12'h085, q);
    chk("R8 protected byte unchanged", q, 16'h00FF, 16'hFFFF);

    unlock();
    wr(12'h555, 16'h0080);
    unlock();
    wr(12'h005, 16'h0031);
    chk("R3 bad erase confirm no busy", {15'h0, busy}, 16'h0, 16'hFFFF);

    erase_seq(12'h005);
    rd(12'h005, q);
    chk("R7 erase poll", q, 16'h0000, 16'h0080);
    wr(12'h555, 16'h00AA);
    wr(12'hAAA, 16'h0055);
    wr(12'h555, 16'h00A0);
    wait_idle(n);
    chk("R7 R10 erase latency", 16'(n + 4), 16'(ELAT), 16'hFFFF);
    wr(12'h007, 16'h0000);
    chk("R10 no command after busy", {15'h0, busy}, 16'h0, 16'hFFFF);
    for (int a = 0; a < 64; a++) model[a] = 8'hFF;
    sweep_bytes("R7 R10 after erase");

    erase_seq(12'h090);
    rd(12'h090, q);
    chk("R9 timeout poll", q, 16'h0000, 16'h0080);
    wait_idle(n);
    chk("R9 timeout length", 16'(n + 1), 16'(TOUT), 16'hFFFF);
    sweep_bytes("R9 nothing erased");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule